// File: doc/BRIEF.md
# Instruction Fetch Cache with Saturating Profiling Counters

This block sits between a processor's instruction-fetch port and a slow, read-only flash array. A fetch whose line is present is answered in the same cycle it is requested. A fetch that is absent starts a line fill from flash. The fill begins with the requested word and wraps around the line. That requested word goes back to the processor as soon as flash delivers it, and the rest of the line is then loaded behind it. Flash access time is a fixed number of wait states, set by a parameter, so that it can track the clock frequency.

A single configuration register holds two independent switches: one turns caching on, the other turns profiling on. Turning caching off makes every line invalid, and every fetch then goes directly to flash. With profiling on, two counters record lookups that hit and lookups that miss. Each counter stops at its all-ones value, and only a system reset clears it. A ready output shows when the flash sequencer is idle. A configuration write is accepted only in that state.

Top module: `icache_prof`

## Requirements
- R1: After reset, both counters read zero, the configuration readback is zero, `flashReady` is 1 and `fetchValid` is 0.
- R2: The configuration readback shows cache enable in bit 0 and profiling enable in bit 8. All other bits read zero. Writing 0x101 sets both, and writing a value with bits 0 and 8 clear sets neither.
- R3: With caching on, a fetch that hits asserts `fetchValid` in the same cycle as `fetchReq`, with the stored word on `fetchData`.
- R4: With caching on, a fetch that misses asserts `fetchValid` in the cycle WAIT_STATES+1 cycles after the request cycle. It returns the flash word at the requested address, with address bits 1:0 ignored.
- R5: A fill loads every word of the line, starting at the requested word and wrapping. While the fill runs, a new fetch is stalled with `fetchValid` low until the fill ends, and it then hits.
- R6: With caching off, every fetch is served from flash with WAIT_STATES+1 cycles of latency, and neither counter changes, even with profiling on.
- R7: After caching is turned off and on again, every line is invalid, so a previously cached address misses.
- R8: With caching and profiling both on, the hit counter rises by one per hit and the miss counter by one per miss.
- R9: Each counter holds at its all-ones value once it reaches it and never wraps to zero.
- R10: With profiling off, both counters hold their values.
- R11: A configuration write made while `flashReady` is low is ignored. During a line fill, `flashReady` is low.
- R12: The cache is direct-mapped. The word offset is taken from address bits above bits 1:0, the line index from the bits above that, and the tag from the rest. A fetch with the same index but a different tag replaces the line, and lines at other indexes are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | input | 1 | Fetch request, held until `fetchValid` |
| fetchAddr | input | ADDR_W | Byte address of the fetch |
| fetchValid | output | 1 | Fetch data valid this cycle |
| fetchData | output | 32 | Instruction word returned |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 32 | Configuration write value |
| cfgRdata | output | 32 | Configuration readback |
| flashReady | output | 1 | Flash sequencer idle; configuration writes accepted |
| hitCount | output | CNT_W | Saturating hit counter |
| missCount | output | CNT_W | Saturating miss counter |
| flashRd | output | 1 | Flash read in progress |
| flashAddr | output | ADDR_W | Word-aligned flash read address |
| flashData | input | 32 | Flash read data, valid after the wait states |

## Verification
The bench builds the cache with four lines of four words, two wait states, 16-bit addresses and 4-bit counters. With four lines, every index and every word offset can be swept, along with index conflicts. With 4-bit counters, both counters reach saturation within a short run: sixteen hits overflow the hit counter, and a run of conflict misses overflows the miss counter. Two wait states make the miss latency and the stall length during a fill differ from every other latency.

// File: rtl/icache_pkg.sv
package icache_pkg;
  // Strobes from the control FSM into the datapath
  typedef struct packed {
    logic cfgLoad;    // latch configuration bits
    logic lineWrite;  // store the current flash word in the line array
    logic tagCommit;  // line complete: write tag, set valid
    logic hitBump;    // count one hit
    logic missBump;   // count one miss
  } ctrlStrobe_t;
endpackage

// File: rtl/icache_satcnt.sv
module icache_satcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rstN)                    count <= '0;
    else if (bump && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/icache_dp.sv
module icache_dp
  import icache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORDS  = 4,
  parameter int LINES  = 16,
  parameter int CNT_W  = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strb,
  input  logic                          cfgEnBit,
  input  logic                          cfgProfBit,
  input  logic [ADDR_W-1:0]             fetchAddr,
  input  logic [ADDR_W-3-$clog2(WORDS):0] fillLine,
  input  logic [$clog2(WORDS)-1:0]      fillWord,
  input  logic [31:0]                   flashData,
  output logic                          cacheEn,
  output logic                          profEn,
  output logic                          lookupHit,
  output logic [31:0]                   hitData,
  output logic [CNT_W-1:0]              hitCount,
  output logic [CNT_W-1:0]              missCount
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int LINE_W = ADDR_W - 2 - OFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;

  logic [TAG_W-1:0] tagMem  [LINES];
  logic [31:0]      dataMem [LINES][WORDS];
  logic [LINES-1:0] validVec;

  logic [IDX_W-1:0] lookIdx, fillIdx;
  logic [TAG_W-1:0] lookTag, fillTag;
  logic [OFF_W-1:0] lookWord;

  assign lookWord = fetchAddr[2 +: OFF_W];
  assign lookIdx  = fetchAddr[2 + OFF_W +: IDX_W];
  assign lookTag  = fetchAddr[ADDR_W-1 -: TAG_W];
  assign fillIdx  = fillLine[IDX_W-1:0];
  assign fillTag  = fillLine[LINE_W-1 -: TAG_W];

  assign lookupHit = validVec[lookIdx] && (tagMem[lookIdx] == lookTag);
  assign hitData   = dataMem[lookIdx][lookWord];

  // configuration register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cacheEn <= 1'b0;
      profEn  <= 1'b0;
    end else if (strb.cfgLoad) begin
      cacheEn <= cfgEnBit;
      profEn  <= cfgProfBit;
    end
  end

  // valid bits: all dropped whenever caching is off
  always_ff @(posedge clk) begin
    if (!rstN)               validVec <= '0;
    else if (!cacheEn)       validVec <= '0;
    else if (strb.tagCommit) validVec[fillIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.tagCommit) tagMem[fillIdx] <= fillTag;
    if (strb.lineWrite) dataMem[fillIdx][fillWord] <= flashData;
  end

  // one saturating counter per event kind
  for (genvar k = 0; k < 2; k++) begin : g_cnt
    logic             bumpK;
    logic [CNT_W-1:0] valK;
    assign bumpK = (k == 0) ? strb.hitBump : strb.missBump;
    icache_satcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rstN(rstN), .bump(bumpK), .count(valK)
    );
  end
  assign hitCount  = g_cnt[0].valK;
  assign missCount = g_cnt[1].valK;
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WORDS       = 4,
  parameter int WAIT_STATES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          fetchReq,
  input  logic [ADDR_W-1:0]             fetchAddr,
  input  logic                          lookupHit,
  input  logic                          cacheEn,
  input  logic                          profEn,
  input  logic                          cfgWe,
  output ctrlStrobe_t                   strb,
  output logic                          fetchValid,
  output logic                          deliverFlash,
  output logic                          flashRd,
  output logic                          flashReady,
  output logic [ADDR_W-1:0]             flashAddr,
  output logic [ADDR_W-3-$clog2(WORDS):0] fillLine,
  output logic [$clog2(WORDS)-1:0]      fillWord
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int LINE_W = ADDR_W - 2 - OFF_W;
  localparam int WS_W   = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;
  localparam logic [WS_W-1:0]  WS_LAST   = WS_W'(WAIT_STATES);
  localparam logic [OFF_W-1:0] WORD_LAST = OFF_W'(WORDS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_BYPASS} state_t;

  state_t            state, nxtState;
  logic [LINE_W-1:0] lineReg;
  logic [OFF_W-1:0]  wordReg, fillCnt;
  logic [WS_W-1:0]   waitCnt;
  logic              critPending;
  logic              lastWait;

  assign lastWait  = (waitCnt == WS_LAST);
  assign flashAddr = {lineReg, wordReg, 2'b00};
  assign fillLine  = lineReg;
  assign fillWord  = wordReg;

  always_comb begin
    strb         = '0;
    fetchValid   = 1'b0;
    deliverFlash = 1'b0;
    flashRd      = 1'b0;
    flashReady   = 1'b0;
    nxtState     = state;
    unique case (state)
      ST_IDLE: begin
        flashReady   = 1'b1;
        strb.cfgLoad = cfgWe;
        if (fetchReq) begin
          if (!cacheEn) begin
            nxtState = ST_BYPASS;
          end else if (lookupHit) begin
            fetchValid   = 1'b1;
            strb.hitBump = profEn;
          end else begin
            nxtState      = ST_FILL;
            strb.missBump = profEn;
          end
        end
      end
      ST_FILL: begin
        flashRd = 1'b1;
        if (lastWait) begin
          strb.lineWrite = 1'b1;
          if (critPending) begin
            fetchValid   = fetchReq;
            deliverFlash = 1'b1;
          end
          if (fillCnt == WORD_LAST) begin
            strb.tagCommit = 1'b1;
            nxtState       = ST_IDLE;
          end
        end
      end
      ST_BYPASS: begin
        flashRd = 1'b1;
        if (lastWait) begin
          fetchValid   = fetchReq;
          deliverFlash = 1'b1;
          nxtState     = ST_IDLE;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      lineReg     <= '0;
      wordReg     <= '0;
      fillCnt     <= '0;
      waitCnt     <= '0;
      critPending <= 1'b0;
    end else begin
      state <= nxtState;
      if (state == ST_IDLE) begin
        if (fetchReq) begin
          lineReg     <= fetchAddr[ADDR_W-1 : 2 + OFF_W];
          wordReg     <= fetchAddr[2 +: OFF_W];
          fillCnt     <= '0;
          waitCnt     <= '0;
          critPending <= 1'b1;
        end
      end else if (lastWait) begin
        waitCnt     <= '0;
        wordReg     <= wordReg + 1'b1;
        fillCnt     <= fillCnt + 1'b1;
        critPending <= 1'b0;
      end else begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/icache_prof.sv
module icache_prof
  import icache_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WORDS       = 4,
  parameter int LINES       = 16,
  parameter int WAIT_STATES = 2,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchValid,
  output logic [31:0]       fetchData,
  input  logic              cfgWe,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  output logic              flashReady,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount,
  output logic              flashRd,
  output logic [ADDR_W-1:0] flashAddr,
  input  logic [31:0]       flashData
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int LINE_W = ADDR_W - 2 - OFF_W;

  ctrlStrobe_t       strb;
  logic              cacheEn, profEn, lookupHit, deliverFlash;
  logic [31:0]       hitData;
  logic [LINE_W-1:0] fillLine;
  logic [OFF_W-1:0]  fillWord;

  icache_ctrl #(.ADDR_W(ADDR_W), .WORDS(WORDS), .WAIT_STATES(WAIT_STATES)) u_ctrl (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .lookupHit(lookupHit), .cacheEn(cacheEn), .profEn(profEn), .cfgWe(cfgWe),
    .strb(strb), .fetchValid(fetchValid), .deliverFlash(deliverFlash),
    .flashRd(flashRd), .flashReady(flashReady), .flashAddr(flashAddr),
    .fillLine(fillLine), .fillWord(fillWord)
  );

  icache_dp #(.ADDR_W(ADDR_W), .WORDS(WORDS), .LINES(LINES), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgEnBit(cfgWdata[0]), .cfgProfBit(cfgWdata[8]),
    .fetchAddr(fetchAddr), .fillLine(fillLine), .fillWord(fillWord),
    .flashData(flashData), .cacheEn(cacheEn), .profEn(profEn),
    .lookupHit(lookupHit), .hitData(hitData),
    .hitCount(hitCount), .missCount(missCount)
  );

  assign fetchData = deliverFlash ? flashData : hitData;
  assign cfgRdata  = {23'b0, profEn, 7'b0, cacheEn};
endmodule

// File: rtl/icache_prof_chk.sv
module icache_prof_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             fetchReq,
  input logic             fetchValid,
  input logic             cfgWe,
  input logic [31:0]      cfgRdata,
  input logic             flashReady,
  input logic [CNT_W-1:0] hitCount,
  input logic [CNT_W-1:0] missCount
);
  localparam logic [CNT_W-1:0] TOP = '1;

  AST_HIT_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    hitCount == TOP |=> hitCount == TOP);  // R9
  AST_MISS_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    missCount == TOP |=> missCount == TOP);  // R9
  AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ##1 (hitCount == $past(hitCount) || hitCount == $past(hitCount) + 1'b1));  // R8
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ##1 (missCount == $past(missCount) || missCount == $past(missCount) + 1'b1));  // R8
  AST_OFF_NO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdata[0] |=> $stable(hitCount) && $stable(missCount));  // R6
  AST_PROF_OFF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdata[8] |=> $stable(hitCount) && $stable(missCount));  // R10
  AST_BUSY_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe && !flashReady |=> $stable(cfgRdata));  // R11
  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> fetchReq);  // R3
endmodule

bind icache_prof icache_prof_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchValid(fetchValid),
  .cfgWe(cfgWe), .cfgRdata(cfgRdata), .flashReady(flashReady),
  .hitCount(hitCount), .missCount(missCount)
);

// File: tb/icache_prof_tb.sv
module icache_prof_tb;
  localparam int PERIOD = 10;
  localparam int AW = 16, WORDS = 4, LINES = 4, WS = 2, CW = 4;
  localparam int CMAX = (1 << CW) - 1;
  localparam int MISS_LAT = WS + 1;
  // fill ends in cycle WORDS*(WS+1)+1; follow-up request starts in cycle WS+3
  localparam int STALL_LAT = WORDS * (WS + 1) + 1 - (WS + 3);

  logic clk = 0, rstN = 0;
  logic fetchReq = 0, cfgWe = 0;
  logic [AW-1:0] fetchAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic fetchValid, flashReady, flashRd;
  logic [31:0] fetchData, cfgRdata, flashData;
  logic [CW-1:0] hitCount, missCount;
  logic [AW-1:0] flashAddr;

  int nChk = 0, nFail = 0, expHit = 0, expMiss = 0;
  bit cacheOn = 0, profOn = 0;

  always #(PERIOD/2) clk = ~clk;

  assign flashData = {flashAddr, flashAddr ^ 16'h5A3C};

  icache_prof #(.ADDR_W(AW), .WORDS(WORDS), .LINES(LINES), .WAIT_STATES(WS), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchValid(fetchValid), .fetchData(fetchData), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .flashReady(flashReady), .hitCount(hitCount),
    .missCount(missCount), .flashRd(flashRd), .flashAddr(flashAddr), .flashData(flashData)
  );

  function automatic logic [31:0] flashWord(logic [AW-1:0] a);
    logic [15:0] w;
    w = {a[15:2], 2'b00};
    return {w, w ^ 16'h5A3C};
  endfunction

  // tag in bits 15:6, index in 5:4, word offset in 3:2
  function automatic logic [AW-1:0] mk(int tag, int idx, int off);
    return AW'((tag << 6) | (idx << 4) | (off << 2));
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic checkCnt(string r);
    chk(r, 32'(hitCount), 32'(expHit));
    chk(r, 32'(missCount), 32'(expMiss));
  endtask

  task automatic waitReady();
    @(negedge clk);
    while (!flashReady) @(negedge clk);
  endtask

  task automatic cfgWrite(logic [31:0] d);
    @(posedge clk); #1;
    cfgWe = 1; cfgWdata = d;
    @(posedge clk); #1;
    cfgWe = 0;
  endtask

  // kind: 0 = bypass, 1 = hit, 2 = miss
  task automatic fetchExp(logic [AW-1:0] a, int expLat, int kind, string r);
    int lat;
    logic [31:0] d;
    @(posedge clk); #1;
    fetchReq = 1; fetchAddr = a; lat = 0;
    forever begin
      @(negedge clk);
      if (fetchValid) break;
      @(posedge clk); #1;
      lat++;
      if (lat > 100) break;
    end
    d = fetchData;
    @(posedge clk); #1;
    fetchReq = 0;
    chk(r, 32'(lat), 32'(expLat));
    chk(r, d, flashWord(a));
    if (cacheOn && profOn) begin
      if (kind == 1 && expHit < CMAX) expHit++;
      if (kind == 2 && expMiss < CMAX) expMiss++;
    end
    checkCnt(r);
  endtask

  initial begin
    #(PERIOD * 200000);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    chk("R1", 32'(hitCount), 0);
    chk("R1", 32'(missCount), 0);
    chk("R1", cfgRdata, 0);
    chk("R1", 32'(flashReady), 1);
    chk("R1", 32'(fetchValid), 0);

    // caching off: everything from flash, nothing counted
    for (int i = 0; i < 6; i++) begin
      fetchExp(mk(i, i % 4, (i + 1) % 4), MISS_LAT, 0, "R6");
      waitReady();
    end
    cfgWrite(32'h100); profOn = 1;
    chk("R2", cfgRdata, 32'h100);
    for (int i = 0; i < 2; i++) begin
      fetchExp(mk(9, i, i), MISS_LAT, 0, "R6");
      waitReady();
    end
    cfgWrite(32'hFFFF_FEFE); profOn = 0;
    chk("R2", cfgRdata, 32'h0);
    cfgWrite(32'h101); profOn = 1; cacheOn = 1;
    chk("R2", cfgRdata, 32'h101);

    // fill every line with a distinct critical word, then hit every word
    for (int idx = 0; idx < LINES; idx++) begin
      fetchExp(mk(3, idx, idx), MISS_LAT, 2, "R4");
      waitReady();
    end
    chk("R8", 32'(missCount), 4);
    for (int idx = 0; idx < LINES; idx++)
      for (int off = 0; off < WORDS; off++)
        fetchExp(mk(3, idx, off), 0, 1, "R3");
    chk("R9", 32'(hitCount), CMAX);

    // stall during fill, then the rest of the line is present
    fetchExp(mk(5, 1, 2), MISS_LAT, 2, "R5");
    fetchExp(mk(5, 1, 0), STALL_LAT, 1, "R5");
    fetchExp(mk(5, 1, 1), 0, 1, "R5");
    fetchExp(mk(5, 1, 3), 0, 1, "R5");

    // direct-mapped conflicts
    fetchExp(mk(3, 1, 0), MISS_LAT, 2, "R12");
    waitReady();
    fetchExp(mk(5, 1, 0), MISS_LAT, 2, "R12");
    waitReady();
    fetchExp(mk(3, 2, 0), 0, 1, "R12");

    // config write during fill is dropped
    fetchExp(mk(6, 0, 1), MISS_LAT, 2, "R11");
    @(negedge clk);
    chk("R11", 32'(flashReady), 0);
    cfgWrite(32'h0);
    waitReady();
    chk("R11", cfgRdata, 32'h101);
    fetchExp(mk(6, 0, 3), 0, 1, "R11");

    // profiling off: counters hold
    cfgWrite(32'h001); profOn = 0;
    chk("R10", cfgRdata, 32'h001);
    fetchExp(mk(6, 0, 1), 0, 1, "R10");
    fetchExp(mk(7, 0, 0), MISS_LAT, 2, "R10");
    waitReady();
    checkCnt("R10");

    // off then on drops all lines
    cfgWrite(32'h101); profOn = 1;
    fetchExp(mk(3, 2, 1), 0, 1, "R7");
    cfgWrite(32'h0); cacheOn = 0;
    cfgWrite(32'h101); cacheOn = 1;
    fetchExp(mk(3, 2, 1), MISS_LAT, 2, "R7");
    waitReady();
    fetchExp(mk(3, 3, 0), MISS_LAT, 2, "R7");
    waitReady();

    // miss counter saturation
    for (int i = 0; i < 15; i++) begin
      fetchExp(mk(8 + (i % 2), 0, 0), MISS_LAT, 2, "R9");
      waitReady();
    end
    chk("R9", 32'(missCount), CMAX);
    chk("R9", 32'(hitCount), CMAX);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule